// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Self-Refresh

This block keeps an asynchronous DRAM array refreshed on behalf of a memory controller. A free-running interval timer raises a refresh demand at the rate that spreads one row per slot across the configured retention window. The window is either 1,024 rows in 16 ms or 2,048 rows in 32 ms. Demands are logged in a small ledger. Whenever the ledger is non-empty, the block asks the host access engine for the bus with a request/grant handshake. Once granted, it runs one refresh cycle per logged demand. A configuration bit picks the refresh style. In the CAS-before-RAS style the DRAM's internal row counter is used and no address is driven. In the RAS-only style the block's own row counter is placed on the address bus while only RAS# is strobed.

The block also sequences a low-power self-refresh mode. A synchronous request first drains any logged refreshes. It then wins the bus and starts a CAS-before-RAS cycle, and keeps RAS# low for a programmable entry hold before it reports self-refresh as active. Dropping the request raises RAS# and CAS# for a programmable recovery time. With the CAS-before-RAS style the bus is then returned to the host. With the RAS-only style the block first refreshes every row back to back.

Top module: `refresh_scheduler`

## Requirements
- R1: With `cfg_large`=0 a refresh demand is raised every CLK_KHZ*WIN_MS_SMALL/ROWS_SMALL clocks, and with `cfg_large`=1 every CLK_KHZ*WIN_MS_LARGE/ROWS_LARGE clocks. When the bus is free, `bus_req` rises once per demand at exactly that spacing.
- R2: With `cfg_ras_only`=0 a refresh cycle drives `cas_n` low alone for one clock. Both strobes are then low for RAS_LOW_CYC clocks, and both are high for PRE_CYC clocks. `addr_oe` stays 0 throughout.
- R3: With `cfg_ras_only`=1 a refresh cycle holds `ras_n` low and `addr_oe`=1 for RAS_LOW_CYC clocks with `cas_n` high, followed by PRE_CYC clocks of precharge. `row_addr` carries the row counter, which advances by one after each such cycle and wraps to 0 after ROWS_SMALL-1 (`cfg_large`=0) or ROWS_LARGE-1 (`cfg_large`=1).
- R4: No strobe goes low before `bus_gnt` has been seen high while `bus_req` is asserted. `bus_req` stays high from the first waiting clock to the last precharge clock, and in its first high clock both strobes are high.
- R5: Up to MAX_OWE demands may be postponed while the bus is withheld. Further demands are dropped, and `refresh_urgent` is 1 exactly while MAX_OWE are outstanding. After a grant, the logged demands are served one after another until `refresh_urgent` clears.
- R6: Self-refresh entry drives `cas_n` low for one clock, then holds both strobes low for max(`cfg_tras_ss`,1) clocks before `sr_active` becomes 1. Both strobes stay low while `sr_active` is 1.
- R7: When `sr_req` is withdrawn, `sr_active` drops and `ras_n` stays high for at least max(`cfg_trps`,1) clocks before it falls again.
- R8: After the recovery time of R7, the CAS-before-RAS style releases `bus_req` at once. The RAS-only style first issues one RAS-only cycle for every row of the configured count, and only then releases `bus_req`.
- R9: Interval demands arising from the start of self-refresh entry to the end of the exit recovery are discarded, so `refresh_urgent` is 0 when self-refresh ends.
- R10: During and right after reset, `ras_n`=1, `cas_n`=1, `bus_req`=0, `addr_oe`=0, `sr_active`=0, `refresh_urgent`=0 and `row_addr`=0.
- R11: `sr_req` is sampled into a register before use. Self-refresh entry waits for `bus_gnt`, and any logged demands are served before entry starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_large | input | 1 | 0: 1,024-row / 16 ms window, 1: 2,048-row / 32 ms window |
| cfg_ras_only | input | 1 | 0: CAS-before-RAS refresh, 1: RAS-only refresh with row counter |
| cfg_tras_ss | input | 16 | Self-refresh entry hold, in clocks |
| cfg_trps | input | 16 | Self-refresh exit recovery, in clocks |
| sr_req | input | 1 | Self-refresh request, level |
| bus_gnt | input | 1 | Bus grant from the host access engine |
| bus_req | output | 1 | Bus request to the host access engine |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr_oe | output | 1 | Row address drive enable |
| row_addr | output | ROW_W | Refresh row for RAS-only cycles |
| sr_active | output | 1 | Self-refresh in progress |
| refresh_urgent | output | 1 | Postponed demands at their limit |

## Verification
An interval demand can land in the same clock as a self-refresh request, during a refresh already in flight, or inside the entry hold or the exit recovery. Whether that demand is logged, served first or discarded decides the whole later waveform. The bench lets self-refresh requests and grant withholding run freely against the free-running timer, so these meetings happen at many phases. A behavioural reference then predicts every strobe, address and status on every clock. Separate monitors measure the entry hold, the exit recovery gap, the number of burst rows and the row sequence directly at the ports.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  localparam int DUR_W = 16;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT,
    ST_CBR_CAS,
    ST_CBR_RAS,
    ST_RO_RAS,
    ST_PRE,
    ST_SR_CAS,
    ST_SR_HOLD,
    ST_SR_ON,
    ST_SR_EXIT
  } rfs_state_e;
endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
  parameter int INT_SMALL = 1562,
  parameter int INT_LARGE = 1562,
  localparam int INT_MAX = (INT_SMALL > INT_LARGE) ? INT_SMALL : INT_LARGE,
  localparam int TW = $clog2(INT_MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_large,
  output logic tick
);
  logic [TW-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit = cfg_large ? TW'(INT_LARGE - 1) : TW'(INT_SMALL - 1);
    tick  = (cnt_q >= limit);
    cnt_d = tick ? '0 : cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rfs_owe_ledger.sv
module rfs_owe_ledger #(
  parameter int MAX_OWE = 8,
  localparam int OW = $clog2(MAX_OWE + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accrue,
  input  logic take,
  output logic have_owe,
  output logic full
);
  logic [OW-1:0] owe_q, owe_d;
  logic          owe_en;

  always_comb begin
    owe_d  = owe_q;
    owe_en = 1'b0;
    if (accrue && !take) begin
      if (owe_q != OW'(MAX_OWE)) begin
        owe_d  = owe_q + OW'(1);
        owe_en = 1'b1;
      end
    end else if (take && !accrue) begin
      owe_d  = owe_q - OW'(1);
      owe_en = 1'b1;
    end
    have_owe = (owe_q != '0);
    full     = (owe_q == OW'(MAX_OWE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      owe_q <= '0;
    else if (owe_en) owe_q <= owe_d;
  end
endmodule

// File: rtl/rfs_row_counter.sv
module rfs_row_counter #(
  parameter int ROWS_SMALL = 1024,
  parameter int ROWS_LARGE = 2048,
  localparam int RW = $clog2(ROWS_LARGE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_large,
  input  logic          step,
  output logic [RW-1:0] row
);
  logic [RW-1:0] row_q, row_d, last;

  always_comb begin
    last  = cfg_large ? RW'(ROWS_LARGE - 1) : RW'(ROWS_SMALL - 1);
    row_d = (row_q >= last) ? '0 : row_q + RW'(1);
    row   = row_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    row_q <= '0;
    else if (step) row_q <= row_d;
  end
endmodule

// File: rtl/rfs_sequencer.sv
module rfs_sequencer
  import rfs_pkg::*;
#(
  parameter int ROWS_SMALL  = 1024,
  parameter int ROWS_LARGE  = 2048,
  parameter int RAS_LOW_CYC = 4,
  parameter int PRE_CYC     = 2,
  localparam int BW = $clog2(ROWS_LARGE) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_large,
  input  logic             cfg_ras_only,
  input  logic [DUR_W-1:0] cfg_tras_ss,
  input  logic [DUR_W-1:0] cfg_trps,
  input  logic             sr_want,
  input  logic             bus_gnt,
  input  logic             have_owe,
  output rfs_state_e       state,
  output logic             take,
  output logic             row_step,
  output logic             accrue_ok
);
  rfs_state_e       st_q, st_d;
  logic [DUR_W-1:0] dur_q, dur_d;
  logic [BW-1:0]    burst_q, burst_d;

  function automatic logic [DUR_W-1:0] len_m1(input logic [DUR_W-1:0] n);
    return (n == '0) ? '0 : n - DUR_W'(1);
  endfunction

  localparam logic [DUR_W-1:0] RAS_LEN = DUR_W'(RAS_LOW_CYC);
  localparam logic [DUR_W-1:0] PRE_LEN = DUR_W'(PRE_CYC);

  always_comb begin
    st_d     = st_q;
    dur_d    = (dur_q != '0) ? dur_q - DUR_W'(1) : '0;
    burst_d  = burst_q;
    take     = 1'b0;
    row_step = 1'b0;
    unique case (st_q)
      ST_IDLE: if (have_owe || sr_want) st_d = ST_WAIT;
      ST_WAIT: begin
        if (!have_owe && !sr_want) begin
          st_d = ST_IDLE;
        end else if (bus_gnt) begin
          if (have_owe) begin
            take = 1'b1;
            if (cfg_ras_only) begin
              st_d  = ST_RO_RAS;
              dur_d = len_m1(RAS_LEN);
            end else begin
              st_d = ST_CBR_CAS;
            end
          end else begin
            st_d = ST_SR_CAS;
          end
        end
      end
      ST_CBR_CAS: begin
        st_d  = ST_CBR_RAS;
        dur_d = len_m1(RAS_LEN);
      end
      ST_CBR_RAS: if (dur_q == '0) begin
        st_d  = ST_PRE;
        dur_d = len_m1(PRE_LEN);
      end
      ST_RO_RAS: if (dur_q == '0) begin
        st_d     = ST_PRE;
        dur_d    = len_m1(PRE_LEN);
        row_step = 1'b1;
        if (burst_q != '0) burst_d = burst_q - BW'(1);
      end
      ST_PRE: if (dur_q == '0) begin
        if (burst_q != '0) begin
          st_d  = ST_RO_RAS;
          dur_d = len_m1(RAS_LEN);
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_SR_CAS: begin
        st_d  = ST_SR_HOLD;
        dur_d = len_m1(cfg_tras_ss);
      end
      ST_SR_HOLD: if (dur_q == '0) st_d = ST_SR_ON;
      ST_SR_ON: if (!sr_want) begin
        st_d  = ST_SR_EXIT;
        dur_d = len_m1(cfg_trps);
      end
      ST_SR_EXIT: if (dur_q == '0) begin
        if (cfg_ras_only) begin
          st_d    = ST_RO_RAS;
          dur_d   = len_m1(RAS_LEN);
          burst_d = cfg_large ? BW'(ROWS_LARGE) : BW'(ROWS_SMALL);
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    accrue_ok = (burst_q == '0) &&
                !(st_q inside {ST_SR_CAS, ST_SR_HOLD, ST_SR_ON, ST_SR_EXIT});
    state = st_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      dur_q   <= '0;
      burst_q <= '0;
    end else begin
      st_q    <= st_d;
      dur_q   <= dur_d;
      burst_q <= burst_d;
    end
  end
endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
  import rfs_pkg::*;
#(
  parameter int CLK_KHZ      = 100000,
  parameter int WIN_MS_SMALL = 16,
  parameter int WIN_MS_LARGE = 32,
  parameter int ROWS_SMALL   = 1024,
  parameter int ROWS_LARGE   = 2048,
  parameter int MAX_OWE      = 8,
  parameter int RAS_LOW_CYC  = 4,
  parameter int PRE_CYC      = 2,
  localparam int ROW_W = $clog2(ROWS_LARGE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_large,
  input  logic             cfg_ras_only,
  input  logic [15:0]      cfg_tras_ss,
  input  logic [15:0]      cfg_trps,
  input  logic             sr_req,
  input  logic             bus_gnt,
  output logic             bus_req,
  output logic             ras_n,
  output logic             cas_n,
  output logic             addr_oe,
  output logic [ROW_W-1:0] row_addr,
  output logic             sr_active,
  output logic             refresh_urgent
);
  localparam int INT_SMALL = CLK_KHZ * WIN_MS_SMALL / ROWS_SMALL;
  localparam int INT_LARGE = CLK_KHZ * WIN_MS_LARGE / ROWS_LARGE;

  logic       sr_req_q;
  logic       tick, accrue_ok, take, row_step, have_owe;
  rfs_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_req_q <= 1'b0;
    else        sr_req_q <= sr_req;
  end

  rfs_interval_timer #(.INT_SMALL(INT_SMALL), .INT_LARGE(INT_LARGE)) u_timer (
    .clk(clk), .rst_n(rst_n), .cfg_large(cfg_large), .tick(tick)
  );

  rfs_owe_ledger #(.MAX_OWE(MAX_OWE)) u_ledger (
    .clk(clk), .rst_n(rst_n), .accrue(tick && accrue_ok), .take(take),
    .have_owe(have_owe), .full(refresh_urgent)
  );

  rfs_row_counter #(.ROWS_SMALL(ROWS_SMALL), .ROWS_LARGE(ROWS_LARGE)) u_rows (
    .clk(clk), .rst_n(rst_n), .cfg_large(cfg_large), .step(row_step), .row(row_addr)
  );

  rfs_sequencer #(
    .ROWS_SMALL(ROWS_SMALL), .ROWS_LARGE(ROWS_LARGE),
    .RAS_LOW_CYC(RAS_LOW_CYC), .PRE_CYC(PRE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_large(cfg_large), .cfg_ras_only(cfg_ras_only),
    .cfg_tras_ss(cfg_tras_ss), .cfg_trps(cfg_trps), .sr_want(sr_req_q),
    .bus_gnt(bus_gnt), .have_owe(have_owe), .state(state), .take(take),
    .row_step(row_step), .accrue_ok(accrue_ok)
  );

  always_comb begin
    bus_req   = (state != ST_IDLE);
    ras_n     = !(state inside {ST_CBR_RAS, ST_RO_RAS, ST_SR_HOLD, ST_SR_ON});
    cas_n     = !(state inside {ST_CBR_CAS, ST_CBR_RAS, ST_SR_CAS, ST_SR_HOLD, ST_SR_ON});
    addr_oe   = (state == ST_RO_RAS);
    sr_active = (state == ST_SR_ON);
  end
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        ras_n,
  input logic        cas_n,
  input logic        addr_oe,
  input logic        sr_active,
  input logic        refresh_urgent,
  input logic [15:0] cfg_trps
);
  logic        sr_d, trk;
  logic [15:0] hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_d <= 1'b0;
      trk  <= 1'b0;
      hi   <= '0;
    end else begin
      sr_d <= sr_active;
      if (sr_d && !sr_active) begin
        trk <= 1'b1;
        hi  <= 16'd1;
      end else if (trk && ras_n) begin
        if (hi != 16'hFFFF) hi <= hi + 16'd1;
      end else if (trk && !ras_n) begin
        trk <= 1'b0;
      end
    end
  end

  assert_cas_leads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !addr_oe) |-> !$past(cas_n));

  assert_ras_only_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oe |-> (!ras_n && cas_n));

  assert_strobe_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> bus_req);

  assert_first_req_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> (ras_n && cas_n));

  assert_urgent_asks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_urgent && !bus_req) |=> bus_req);

  assert_sr_strobes_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sr_active |-> (!ras_n && !cas_n));

  assert_exit_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trk && !ras_n) |-> (hi >= cfg_trps));
endmodule

bind refresh_scheduler rfs_checker u_rfs_checker (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .ras_n(ras_n), .cas_n(cas_n),
  .addr_oe(addr_oe), .sr_active(sr_active), .refresh_urgent(refresh_urgent),
  .cfg_trps(cfg_trps)
);

// File: tb/tb_refresh_scheduler.sv
module tb_refresh_scheduler;
  localparam int CLK_KHZ = 64, WS = 16, WL = 48, RS = 16, RL = 32;
  localparam int MAXO = 3, RASC = 3, PREC = 2;
  localparam int INT_S = CLK_KHZ * WS / RS;   // 64
  localparam int INT_L = CLK_KHZ * WL / RL;   // 96
  localparam int TRAS = 5, TRPS = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cfg_large, cfg_ras_only, sr_req, bus_gnt, bus_req;
  logic ras_n, cas_n, addr_oe, sr_active, refresh_urgent, allow;
  logic [15:0] cfg_tras_ss, cfg_trps;
  logic [4:0] row_addr;

  assign bus_gnt = bus_req & allow;

  refresh_scheduler #(
    .CLK_KHZ(CLK_KHZ), .WIN_MS_SMALL(WS), .WIN_MS_LARGE(WL), .ROWS_SMALL(RS),
    .ROWS_LARGE(RL), .MAX_OWE(MAXO), .RAS_LOW_CYC(RASC), .PRE_CYC(PREC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cfg_large(cfg_large), .cfg_ras_only(cfg_ras_only),
    .cfg_tras_ss(cfg_tras_ss), .cfg_trps(cfg_trps), .sr_req(sr_req),
    .bus_gnt(bus_gnt), .bus_req(bus_req), .ras_n(ras_n), .cas_n(cas_n),
    .addr_oe(addr_oe), .row_addr(row_addr), .sr_active(sr_active),
    .refresh_urgent(refresh_urgent)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Behavioural reference: phase numbers 0 idle, 1 waiting, 2 cas-lead, 3 cbr strobe,
  // 4 row strobe, 5 precharge, 6 sr cas-lead, 7 sr hold, 8 sr on, 9 sr recovery.
  int m_ph, m_left, m_tmr, m_owe, m_row, m_burst;
  bit m_srq;

  function automatic int less1(input int n);
    return (n <= 0) ? 0 : n - 1;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_tmr = 0; m_owe = 0; m_row = 0; m_burst = 0; m_srq = 0;
    end else begin
      int lim, nph, nleft, nburst;
      bit tick, acct, gnt, tk, st;
      lim  = cfg_large ? INT_L - 1 : INT_S - 1;
      tick = (m_tmr >= lim);
      acct = (m_burst == 0) && !(m_ph >= 6);
      gnt  = (m_ph != 0) && allow;
      nph = m_ph; nleft = less1(m_left); nburst = m_burst; tk = 0; st = 0;
      if (m_ph == 0) begin
        if (m_owe > 0 || m_srq) nph = 1;
      end else if (m_ph == 1) begin
        if (m_owe == 0 && !m_srq) nph = 0;
        else if (gnt) begin
          if (m_owe > 0) begin
            tk = 1;
            if (cfg_ras_only) begin nph = 4; nleft = RASC - 1; end
            else nph = 2;
          end else nph = 6;
        end
      end else if (m_ph == 2) begin
        nph = 3; nleft = RASC - 1;
      end else if (m_ph == 3 || m_ph == 4) begin
        if (m_left == 0) begin
          nph = 5; nleft = PREC - 1;
          if (m_ph == 4) begin st = 1; if (m_burst > 0) nburst = m_burst - 1; end
        end
      end else if (m_ph == 5) begin
        if (m_left == 0) begin
          if (m_burst > 0) begin nph = 4; nleft = RASC - 1; end else nph = 0;
        end
      end else if (m_ph == 6) begin
        nph = 7; nleft = less1(cfg_tras_ss);
      end else if (m_ph == 7) begin
        if (m_left == 0) nph = 8;
      end else if (m_ph == 8) begin
        if (!m_srq) begin nph = 9; nleft = less1(cfg_trps); end
      end else if (m_ph == 9) begin
        if (m_left == 0) begin
          if (cfg_ras_only) begin nph = 4; nleft = RASC - 1; nburst = cfg_large ? RL : RS; end
          else nph = 0;
        end
      end
      if (tick && acct && !tk) begin if (m_owe < MAXO) m_owe++; end
      else if (tk && !(tick && acct)) m_owe--;
      if (st) m_row = (m_row >= (cfg_large ? RL - 1 : RS - 1)) ? 0 : m_row + 1;
      m_tmr = tick ? 0 : m_tmr + 1;
      m_ph = nph; m_left = nleft; m_burst = nburst; m_srq = sr_req;
    end
  end

  // Per-clock comparison and port monitors.
  bit prev_sr, prev_ras, prev_bus, prev_oe, have_last, in_exit;
  int hold_cnt, hi, falls, first_hi, last_row, ras_falls;

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_ras, e_cas;
      e_ras = !(m_ph == 3 || m_ph == 4 || m_ph == 7 || m_ph == 8);
      e_cas = !(m_ph == 2 || m_ph == 3 || m_ph == 6 || m_ph == 7 || m_ph == 8);
      chk(ras_n == e_ras, "R2 ras_n", ras_n, e_ras);
      chk(cas_n == e_cas, "R2 cas_n", cas_n, e_cas);
      chk(addr_oe == (m_ph == 4), "R3 addr_oe", addr_oe, m_ph == 4);
      chk(row_addr == m_row, "R3 row_addr", row_addr, m_row);
      chk(bus_req == (m_ph != 0), "R4 bus_req", bus_req, m_ph != 0);
      chk(sr_active == (m_ph == 8), "R6 R11 sr_active", sr_active, m_ph == 8);
      chk(refresh_urgent == (m_owe == MAXO), "R5 refresh_urgent", refresh_urgent, m_owe == MAXO);

      if (prev_ras && !ras_n) ras_falls++;
      // R6: entry hold length measured from the strobes
      if (!ras_n && !cas_n && !sr_active) hold_cnt++;
      else if (ras_n) hold_cnt = 0;
      if (sr_active && !prev_sr) chk(hold_cnt == TRAS, "R6 entry hold", hold_cnt, TRAS);
      // R3: row sequence with wrap
      if (addr_oe && !prev_oe) begin
        if (have_last) begin
          int exp_row;
          exp_row = (last_row + 1) % (cfg_large ? RL : RS);
          chk(row_addr == exp_row, "R3 row step", row_addr, exp_row);
        end
        have_last = 1; last_row = row_addr;
      end
      // R7, R8, R9: exit recovery and burst
      if (prev_sr && !sr_active) begin
        in_exit = 1; hi = 1; falls = 0; first_hi = 0;
        chk(refresh_urgent == 0, "R9 no demand kept across self-refresh", refresh_urgent, 0);
      end else if (in_exit) begin
        if (prev_bus && !bus_req) begin
          in_exit = 0;
          if (cfg_ras_only) begin
            chk(falls == RS, "R8 burst rows", falls, RS);
            chk(first_hi == TRPS, "R7 recovery before burst", first_hi, TRPS);
          end else begin
            chk(falls == 0, "R8 no burst", falls, 0);
            chk(hi == TRPS, "R7 recovery length", hi, TRPS);
          end
        end else if (prev_ras && !ras_n) begin
          falls++;
          if (falls == 1) first_hi = hi;
        end else if (ras_n && falls == 0) hi++;
      end
      prev_sr = sr_active; prev_ras = ras_n; prev_bus = bus_req; prev_oe = addr_oe;
    end
  end

  task automatic bus_rise(output int at);
    do @(negedge clk); while (bus_req);
    do @(negedge clk); while (!bus_req);
    at = cyc;
  endtask

  task automatic wait_sr(input bit lvl);
    do @(negedge clk); while (sr_active != lvl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    report();
  end

  initial begin
    int t1, t2, f0;
    rst_n = 0; cfg_large = 0; cfg_ras_only = 0; sr_req = 0; allow = 1;
    cfg_tras_ss = 16'(TRAS); cfg_trps = 16'(TRPS);
    prev_sr = 0; prev_ras = 1; prev_bus = 0; prev_oe = 0; have_last = 0; in_exit = 0;
    hold_cnt = 0; hi = 0; falls = 0; first_hi = 0; last_row = 0; ras_falls = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(ras_n && cas_n, "R10 strobes high", {ras_n, cas_n}, 3);
    chk(!bus_req && !addr_oe && !sr_active && !refresh_urgent, "R10 outputs low",
        {bus_req, addr_oe, sr_active, refresh_urgent}, 0);
    chk(row_addr == 0, "R10 row", row_addr, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!bus_req && ras_n && cas_n, "R10 after release", bus_req, 0);

    // R1: demand spacing in both windows (CBR style, R2 shape via reference)
    bus_rise(t1); bus_rise(t2);
    chk(t2 - t1 == INT_S, "R1 small window spacing", t2 - t1, INT_S);
    cfg_large = 1;
    bus_rise(t1); bus_rise(t1); bus_rise(t2);
    chk(t2 - t1 == INT_L, "R1 large window spacing", t2 - t1, INT_L);

    // R3: RAS-only cycles with row wrap in the small window
    cfg_large = 0; cfg_ras_only = 1;
    repeat (20 * INT_S) @(negedge clk);

    // R5: postponement cap, then drain
    allow = 0;
    repeat (5 * INT_S) @(negedge clk);
    chk(refresh_urgent == 1, "R5 cap reached", refresh_urgent, 1);
    chk(ras_n && cas_n, "R4 no strobe without grant", {ras_n, cas_n}, 3);
    f0 = ras_falls; allow = 1;
    repeat (30) @(negedge clk);
    chk(ras_falls - f0 >= MAXO, "R5 drained back to back", ras_falls - f0, MAXO);
    chk(refresh_urgent == 0, "R5 cap cleared", refresh_urgent, 0);

    // R6, R7, R8, R9: self-refresh in CBR style
    cfg_ras_only = 0;
    sr_req = 1; wait_sr(1);
    repeat (300) @(negedge clk);
    chk(sr_active && bus_req, "R9 still in self-refresh", sr_active, 1);
    sr_req = 0; wait_sr(0);
    repeat (40) @(negedge clk);

    // R8: self-refresh in RAS-only style needs a full burst
    cfg_ras_only = 1;
    sr_req = 1; wait_sr(1);
    repeat (250) @(negedge clk);
    sr_req = 0; wait_sr(0);
    repeat (150) @(negedge clk);

    // R11: entry waits for the grant
    allow = 0; sr_req = 1;
    repeat (20) @(negedge clk);
    chk(sr_active == 0, "R11 entry held off without grant", sr_active, 0);
    allow = 1; wait_sr(1);
    repeat (30) @(negedge clk);
    sr_req = 0; wait_sr(0);
    repeat (150) @(negedge clk);
    report();
  end
endmodule